// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Bus

This block is a slave on a two-wire serial bus (I2C signalling). It gives a host access to a bank of 8-bit configuration registers. Both the clock and the data line are sampled with a fast system clock, so the block holds no logic in the bus clock domain. The slave releases the data line or pulls it low. The register storage sits outside the block and is reached through a simple read/write port. One register, the read byte-count register, is held inside the block.

A block write sends the write address (0xD2), then a starting index, then a byte count X, then X data bytes. Each accepted data byte goes to the register port at the running index, and the index then advances. A block read sets the index with a short write phase (0xD2, index), then a repeated start and the read address (0xD3). The slave first returns the contents of its byte-count register and then data bytes from the running index. It carries on for as long as the master acknowledges. A master NACK ends the transfer.

The index advances after every data byte and wraps from the top of the bank back to zero. Only the low log2(NREG) bits of the received index byte select a register.

Top module: `ixreg_top`

## Requirements
- R1: Address byte 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte is not acknowledged. After that the slave never drives SDA and issues no register write until the next start.
- R2: In a write, the index byte and the count byte are acknowledged. Each of the following X data bytes is also acknowledged, and it appears on the register port as a one-cycle `regWe` carrying `regAddr` equal to the running index and `regWdata` equal to the byte. The bytes go in order N, N+1, ...
- R3: A data byte beyond the count X of the current write is not acknowledged and is not written. SDA stays released until the next start.
- R4: After a 0xD3 address is acknowledged, the first byte the slave sends is the value of the byte-count register.
- R5: The read data bytes that follow come from the register at the running index. They are sent MSB first, and each one advances the index. A master ACK (SDA low) requests the next byte.
- R6: The running index wraps from NREG-1 to 0, in both writes and reads.
- R7: The byte-count register lives at index 8 and resets to 0x0F. A write to index 8 updates it and is also presented on the register port. Later reads report the new value as their count byte.
- R8: A master NACK (SDA high) after a read byte ends the transfer. The slave keeps SDA released until the next start or stop.
- R9: The slave changes its SDA drive only while the synchronised SCL is low.
- R10: After reset SDA is released, `regWe` is low and the index is 0.
- R11: A write whose count byte is 0 accepts no data. The first data byte is not acknowledged and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock as seen on the wire |
| sdaIn | input | 1 | Bus data as seen on the wire |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| regAddr | output | log2(NREG) | Running register index, used for reads and writes |
| regWe | output | 1 | One-cycle register write strobe |
| regWdata | output | 8 | Byte to write |
| regRdata | input | 8 | Register contents at `regAddr` |

## Verification
The bench goes after a write that overruns its count. A slave that ignored the count would ACK the extra byte and corrupt the next register. It also runs a zero-count write, where a wrong design writes one byte, and a foreign address followed by write-shaped traffic, which a slave that only dropped the ACK would still store. Reads and writes that cross the top of the bank expose an index that saturates or runs off the end. Reading the count byte before and after reprogramming index 8 catches a count fixed at its reset value. A per-clock watch on SDA catches a slave that keeps driving after the master NACK, or that moves SDA while SCL is high and so fakes a start or stop.

// File: rtl/ixreg_pkg.sv
`timescale 1ns/1ps
package ixreg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACKWAIT, S_ACK, S_TX, S_MACK, S_IGNORE
  } busState_e;

  typedef enum logic [1:0] {
    ROLE_ADDR, ROLE_INDEX, ROLE_COUNT, ROLE_DATA
  } byteRole_e;

  // control -> datapath
  typedef struct packed {
    logic bitClr;
    logic bitStep;
    logic rxShift;
    logic txShift;
    logic txLoadCnt;
    logic txLoadReg;
    logic oeAck;
    logic oeOff;
    logic idxLoad;
    logic idxInc;
    logic remLoad;
    logic remDec;
    logic wrEn;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic bitLast;
    logic remZero;
    logic sdaBit;
    logic [BYTE_W-1:0] rxByte;
  } dpStatus_t;
endpackage

// File: rtl/ixreg_dp.sv
`timescale 1ns/1ps
module ixreg_dp import ixreg_pkg::*; #(
  parameter int NREG = 16,
  parameter int CNT_IDX = 8,
  parameter logic [BYTE_W-1:0] CNT_RST = 8'h0F,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  input  logic [BYTE_W-1:0] regRdata,
  output dpStatus_t         stat,
  output logic              sclSync,
  output logic              sdaOe,
  output logic [IDXW-1:0]   regAddr,
  output logic              regWe,
  output logic [BYTE_W-1:0] regWdata
);
  localparam logic [IDXW-1:0] CNT_SEL = IDXW'(CNT_IDX);

  logic [SYNC_STAGES:0] sclPipe, sdaPipe;
  logic sclS, sclD, sdaS, sdaD;
  logic [2:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg, countReg, remain;
  logic [IDXW-1:0] idx;
  logic [BYTE_W-1:0] rxByte;

  // synchroniser plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sclD = sclPipe[SYNC_STAGES];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sdaD = sdaPipe[SYNC_STAGES];
  assign rxByte = {shiftReg[BYTE_W-2:0], sdaS};

  assign stat.sclRise  = sclS & ~sclD;
  assign stat.sclFall  = ~sclS & sclD;
  assign stat.startDet = sclS & sclD & sdaD & ~sdaS;
  assign stat.stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign stat.bitLast  = (bitCnt == 3'd7);
  assign stat.remZero  = (remain == '0);
  assign stat.sdaBit   = sdaS;
  assign stat.rxByte   = rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      sdaOe    <= 1'b0;
      idx      <= '0;
      remain   <= '0;
      countReg <= CNT_RST;
    end else begin
      if (strb.bitClr) bitCnt <= '0;
      else if (strb.bitStep) bitCnt <= bitCnt + 3'd1;

      if (strb.rxShift) shiftReg <= rxByte;
      else if (strb.txLoadCnt) shiftReg <= countReg;
      else if (strb.txLoadReg) shiftReg <= regRdata;
      else if (strb.txShift) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};

      if (strb.oeOff) sdaOe <= 1'b0;
      else if (strb.oeAck) sdaOe <= 1'b1;
      else if (strb.txLoadCnt) sdaOe <= ~countReg[BYTE_W-1];
      else if (strb.txLoadReg) sdaOe <= ~regRdata[BYTE_W-1];
      else if (strb.txShift) sdaOe <= ~shiftReg[BYTE_W-2];

      if (strb.idxLoad) idx <= rxByte[IDXW-1:0];
      else if (strb.idxInc) idx <= idx + 1'b1;

      if (strb.remLoad) remain <= rxByte;
      else if (strb.remDec) remain <= remain - 1'b1;

      if (strb.wrEn && idx == CNT_SEL) countReg <= rxByte;
    end
  end

  assign sclSync  = sclS;
  assign regAddr  = idx;
  assign regWe    = strb.wrEn;
  assign regWdata = rxByte;
endmodule

// File: rtl/ixreg_ctrl.sv
`timescale 1ns/1ps
module ixreg_ctrl import ixreg_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStatus_t stat,
  output dpStrobe_t strb
);
  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] ADDR_RD = {DEV_ADDR, 1'b1};

  busState_e state, stateN;
  byteRole_e role, roleN;
  logic ackReg, ackN, txMode, txModeN, mackOk, mackN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      role   <= ROLE_ADDR;
      ackReg <= 1'b0;
      txMode <= 1'b0;
      mackOk <= 1'b0;
    end else begin
      state  <= stateN;
      role   <= roleN;
      ackReg <= ackN;
      txMode <= txModeN;
      mackOk <= mackN;
    end
  end

  always_comb begin
    strb    = '0;
    stateN  = state;
    roleN   = role;
    ackN    = ackReg;
    txModeN = txMode;
    mackN   = mackOk;
    if (stat.startDet) begin
      stateN      = S_RX;
      roleN       = ROLE_ADDR;
      txModeN     = 1'b0;
      strb.bitClr = 1'b1;
      strb.oeOff  = 1'b1;
    end else if (stat.stopDet) begin
      stateN     = S_IDLE;
      strb.oeOff = 1'b1;
    end else begin
      case (state)
        S_RX: if (stat.sclRise) begin
          strb.rxShift = 1'b1;
          strb.bitStep = 1'b1;
          if (stat.bitLast) begin
            stateN = S_ACKWAIT;
            ackN   = 1'b0;
            case (role)
              ROLE_ADDR: begin
                if (stat.rxByte == ADDR_WR) begin
                  ackN  = 1'b1;
                  roleN = ROLE_INDEX;
                end else if (stat.rxByte == ADDR_RD) begin
                  ackN    = 1'b1;
                  txModeN = 1'b1;
                end
              end
              ROLE_INDEX: begin
                ackN         = 1'b1;
                strb.idxLoad = 1'b1;
                roleN        = ROLE_COUNT;
              end
              ROLE_COUNT: begin
                ackN         = 1'b1;
                strb.remLoad = 1'b1;
                roleN        = ROLE_DATA;
              end
              default: if (!stat.remZero) begin
                ackN        = 1'b1;
                strb.wrEn   = 1'b1;
                strb.idxInc = 1'b1;
                strb.remDec = 1'b1;
              end
            endcase
          end
        end
        S_ACKWAIT: if (stat.sclFall) begin
          if (ackReg) begin
            strb.oeAck = 1'b1;
            stateN     = S_ACK;
          end else begin
            stateN = S_IGNORE;
          end
        end
        S_ACK: if (stat.sclFall) begin
          if (txMode) begin
            strb.txLoadCnt = 1'b1;
            stateN         = S_TX;
          end else begin
            strb.oeOff = 1'b1;
            stateN     = S_RX;
          end
        end
        S_TX: if (stat.sclFall) begin
          strb.bitStep = 1'b1;
          if (stat.bitLast) begin
            strb.oeOff = 1'b1;
            mackN      = 1'b0;
            stateN     = S_MACK;
          end else begin
            strb.txShift = 1'b1;
          end
        end
        S_MACK: begin
          if (stat.sclRise) begin
            mackN = ~stat.sdaBit;
          end else if (stat.sclFall) begin
            if (mackOk) begin
              strb.txLoadReg = 1'b1;
              strb.idxInc    = 1'b1;
              stateN         = S_TX;
            end else begin
              stateN = S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ixreg_top.sv
`timescale 1ns/1ps
module ixreg_top import ixreg_pkg::*; #(
  parameter int NREG = 16,
  parameter int CNT_IDX = 8,
  parameter logic [7:0] CNT_RST = 8'h0F,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  output logic            sdaOe,
  output logic [IDXW-1:0] regAddr,
  output logic            regWe,
  output logic [7:0]      regWdata,
  input  logic [7:0]      regRdata
);
  dpStrobe_t strb;
  dpStatus_t stat;
  logic sclSync;

  ixreg_dp #(
    .NREG(NREG), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .regRdata(regRdata), .stat(stat), .sclSync(sclSync), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata)
  );

  ixreg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .strb(strb)
  );
endmodule

// File: rtl/ixreg_chk.sv
`timescale 1ns/1ps
module ixreg_chk #(
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            sclSync,
  input logic            sdaOe,
  input logic            regWe,
  input logic [IDXW-1:0] regAddr
);
  p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclSync);

  p_we_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  p_we_on_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> sclSync);

  p_we_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !sdaOe);

  p_idx_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> regAddr == IDXW'($past(regAddr) + 1'b1));
endmodule

bind ixreg_top ixreg_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaOe(sdaOe),
  .regWe(regWe), .regAddr(regAddr)
);

// File: tb/sim_ixreg_top.sv
`timescale 1ns/1ps
module sim_ixreg_top;
  localparam int NREG = 16;
  localparam int IDXW = 4;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaBus, sdaOe, regWe;
  logic [IDXW-1:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic [7:0] regFile [NREG];
  int total = 0, bad = 0, strayWr = 0, quietViol = 0, r9Viol = 0;
  bit mustQuiet = 0, wrAllowed = 0, done = 0;
  logic prevOe = 1'b0;
  logic ackBit;
  logic [7:0] rb;

  always #4 clk = ~clk;

  assign sdaBus = mSda & ~sdaOe;
  assign regRdata = regFile[regAddr];

  ixreg_top #(.NREG(NREG)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata)
  );

  // register storage behind the port, plus the stray-write watch
  always @(negedge clk) begin
    if (rstN && regWe) begin
      regFile[regAddr] = regWdata;
      if (!wrAllowed) strayWr++;
    end
  end

  // per-clock watch of the SDA drive
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      if (mustQuiet && sdaOe) quietViol++;
      if (sdaOe !== prevOe && mScl) r9Viol++;
      prevOe = sdaOe;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ();
      mScl = 1'b1; waitQ(); waitQ();
      mScl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    ack = sdaBus; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic sendExpect(input logic [7:0] b, input logic expAck, input string tag);
    logic a;
    sendByte(b, a);
    check(tag, a, expAck);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      mScl = 1'b1; waitQ();
      b[i] = sdaBus; waitQ();
      mScl = 1'b0;
    end
    waitQ();
    mSda = ackIt ? 1'b0 : 1'b1; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) regFile[i] = 8'hA0 + 8'(i);
    repeat (3) @(negedge clk);
    check("R10 sdaOe in reset", sdaOe, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 sdaOe after reset", sdaOe, 0);
    check("R10 regWe after reset", regWe, 0);
    check("R10 index after reset", regAddr, 0);

    // R2: plain block write of three bytes at index 2
    wrAllowed = 1;
    i2cStart();
    sendExpect(8'hD2, 0, "R1 write address ack");
    sendExpect(8'h02, 0, "R2 index ack");
    sendExpect(8'h03, 0, "R2 count ack");
    sendExpect(8'h11, 0, "R2 data0 ack");
    sendExpect(8'h22, 0, "R2 data1 ack");
    sendExpect(8'h33, 0, "R2 data2 ack");
    i2cStop();
    check("R2 reg2", regFile[2], 8'h11);
    check("R2 reg3", regFile[3], 8'h22);
    check("R2 reg4", regFile[4], 8'h33);

    // R3: one byte more than the count
    i2cStart();
    sendExpect(8'hD2, 0, "R3 address ack");
    sendExpect(8'h05, 0, "R3 index ack");
    sendExpect(8'h02, 0, "R3 count ack");
    sendExpect(8'h44, 0, "R3 data0 ack");
    sendExpect(8'h55, 0, "R3 data1 ack");
    wrAllowed = 0;
    mustQuiet = 1;
    sendExpect(8'h66, 1, "R3 extra byte nack");
    i2cStop();
    mustQuiet = 0;
    check("R3 reg5", regFile[5], 8'h44);
    check("R3 reg6", regFile[6], 8'h55);
    check("R3 reg7 untouched", regFile[7], 8'hA7);

    // R11: zero count
    i2cStart();
    sendExpect(8'hD2, 0, "R11 address ack");
    sendExpect(8'h09, 0, "R11 index ack");
    sendExpect(8'h00, 0, "R11 count ack");
    sendExpect(8'h77, 1, "R11 data nack");
    i2cStop();
    check("R11 reg9 untouched", regFile[9], 8'hA9);

    // R6: write across the top of the bank
    wrAllowed = 1;
    i2cStart();
    sendExpect(8'hD2, 0, "R6 address ack");
    sendExpect(8'h0F, 0, "R6 index ack");
    sendExpect(8'h03, 0, "R6 count ack");
    sendExpect(8'h01, 0, "R6 data0 ack");
    sendExpect(8'h02, 0, "R6 data1 ack");
    sendExpect(8'h03, 0, "R6 data2 ack");
    i2cStop();
    wrAllowed = 0;
    check("R6 reg15", regFile[15], 8'h01);
    check("R6 reg0 wrapped", regFile[0], 8'h02);
    check("R6 reg1 wrapped", regFile[1], 8'h03);

    // R1: foreign address, then write-shaped traffic
    i2cStart();
    mustQuiet = 1;
    sendExpect(8'hA4, 1, "R1 foreign address nack");
    sendExpect(8'h03, 1, "R1 ignored byte");
    sendExpect(8'h01, 1, "R1 ignored byte");
    sendExpect(8'h99, 1, "R1 ignored byte");
    i2cStop();
    mustQuiet = 0;
    check("R1 sda never driven", quietViol, 0);
    check("R1 no stray write", strayWr, 0);
    check("R1 reg3 untouched", regFile[3], 8'h22);

    // R4 R5 R8: block read from index 2
    i2cStart();
    sendExpect(8'hD2, 0, "R4 write phase ack");
    sendExpect(8'h02, 0, "R5 index ack");
    i2cStart();
    sendExpect(8'hD3, 0, "R1 read address ack");
    recvByte(1, rb);
    check("R4 R7 reset count byte", rb, 8'h0F);
    recvByte(1, rb);
    check("R5 data idx2", rb, 8'h11);
    recvByte(1, rb);
    check("R5 data idx3", rb, 8'h22);
    recvByte(0, rb);
    check("R5 data idx4", rb, 8'h33);
    mustQuiet = 1;
    waitQ(); waitQ(); waitQ(); waitQ();
    check("R8 sda released after nack", sdaBus, 1);
    i2cStop();
    mustQuiet = 0;
    check("R8 no drive after nack", quietViol, 0);

    // R7: reprogram the count register, then read across the top
    wrAllowed = 1;
    i2cStart();
    sendExpect(8'hD2, 0, "R7 address ack");
    sendExpect(8'h08, 0, "R7 index ack");
    sendExpect(8'h01, 0, "R7 count ack");
    sendExpect(8'h04, 0, "R7 data ack");
    i2cStop();
    wrAllowed = 0;
    check("R7 port write of count", regFile[8], 8'h04);
    i2cStart();
    sendExpect(8'hD2, 0, "R6 read write phase ack");
    sendExpect(8'h0E, 0, "R6 read index ack");
    i2cStart();
    sendExpect(8'hD3, 0, "R4 read address ack");
    recvByte(1, rb);
    check("R7 new count byte", rb, 8'h04);
    recvByte(1, rb);
    check("R5 data idx14", rb, 8'hAE);
    recvByte(1, rb);
    check("R6 data idx15", rb, 8'h01);
    recvByte(0, rb);
    check("R6 read wrapped idx0", rb, 8'h02);
    i2cStop();

    waitQ();
    check("R9 sda changes only with scl low", r9Viol, 0);
    check("R3 no stray write overall", strayWr, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule